// File: doc/BRIEF.md
# Segmented Streaming Memory Tile

This block is a small on-chip memory tile that serves one compute element at a time. A supervisor configures it into one of three modes: random-access read/write, stream-out (the tile plays stored tokens out over a valid/ready port), or stream-in (the tile captures a valid/ready token stream into storage). Only one stream engine exists, so at most one stream port is live at any moment.

Every access is fenced by an inclusive pair of segment bounds, low and high. An access that falls outside the segment, or beyond the storage capacity for the chosen token width, performs no write. It raises a sticky fault flag that records the first offending token address until the supervisor clears it. Tokens are 8, 16 or 32 bits wide and are packed little-endian into 32-bit storage words. Capacity in tokens is therefore four, two or one times the word count.

The control state machine has five states:
- `ST_IDLE` is the configurable state.
- `ST_RAND` serves the random-access port.
- `ST_SRC` streams tokens out.
- `ST_SNK` captures tokens in.
- `ST_END` is the halted state after a stream leaves its segment.

The transitions are:
- IDLE→RAND, IDLE→SRC and IDLE→SNK on a start command, chosen by the stored mode.
- SRC→END and SNK→END when the stream pointer leaves the segment.
- RAND, SRC, SNK or END→IDLE on a stop command. Stop takes priority over leaving the segment.

Top module: `seg_stream_mem`

## Requirements
- R1: After reset the tile is idle: `busy`=0, `fault`=0, `so_valid`=0, `si_ready`=0.
- R2: A configuration write (`cfg_we`) is taken only in IDLE, and only with mode code 0 (random), 1 (stream-out) or 2 (stream-in) and size code 0 (8-bit), 1 (16-bit) or 2 (32-bit). A write while busy, or with code 3 in either field, changes nothing.
- R3: `cmd_go` in IDLE enters the state selected by the stored mode and raises `busy`. `cmd_stop` returns any active state to IDLE.
- R4: In random mode, an in-segment write stores the token. An in-segment read returns the token zero-extended on `ra_rdata`, with `ra_rvalid`=1 one cycle after the request.
- R5: Token address t is packed as follows. For 8-bit tokens it goes to word t/4, byte lane t mod 4. For 16-bit tokens it goes to word t/2, lane 2·(t mod 2). For 32-bit tokens it goes to word t. Lane 0 is bits 7:0.
- R6: Stream-out starts at the low bound and advances one token per `so_valid`&&`so_ready` handshake, in ascending address order. `so_data` holds steady while `so_ready` is low.
- R7: After the token at the high bound is taken, `so_valid` drops at once and never wraps. One cycle later `fault`=1 with `fault_addr`=high+1, and the tile halts (busy) until stopped.
- R8: Stream-in holds `si_ready` high while the pointer is in segment and writes tokens from the low bound upward. Past the high bound, `si_ready` drops and `fault_addr`=high+1.
- R9: An out-of-segment random access writes nothing, returns no `ra_rvalid`, and sets `fault` with `fault_addr` equal to the access address.
- R10: `fault` is sticky, including across stop. `fault_addr` keeps the first offending address until `fault_clr`. A new fault in the same cycle as `fault_clr` wins.
- R11: `so_valid` and `si_ready` are never both high. The random port has no effect outside random mode.
- R12: An address beyond capacity for the token width, or an inverted segment (low > high), faults on the first access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code: 0 random, 1 stream-out, 2 stream-in |
| cfg_size | input | 2 | Token size code: 0 8-bit, 1 16-bit, 2 32-bit |
| cfg_lo | input | TA_W (6) | Segment low bound, token address |
| cfg_hi | input | TA_W (6) | Segment high bound, inclusive |
| cmd_go | input | 1 | Start the configured mode |
| cmd_stop | input | 1 | Return to idle |
| busy | output | 1 | High when not idle |
| ra_en | input | 1 | Random access request |
| ra_we | input | 1 | Random access is a write |
| ra_addr | input | TA_W (6) | Random access token address |
| ra_wdata | input | 32 | Random write token, low bits used |
| ra_rdata | output | 32 | Random read token, zero-extended |
| ra_rvalid | output | 1 | Read data valid |
| so_valid | output | 1 | Stream-out token present |
| so_ready | input | 1 | Stream-out back-pressure |
| so_data | output | 32 | Stream-out token |
| si_valid | input | 1 | Stream-in token present |
| si_ready | output | 1 | Stream-in space available |
| si_data | input | 32 | Stream-in token |
| fault | output | 1 | Sticky segment fault flag |
| fault_addr | output | TA_W+1 (7) | First offending token address |
| fault_clr | input | 1 | Clear the fault flag |

## Verification
The bench builds the tile with the default of 16 storage words. This gives 6-bit token addresses and capacities of 64, 32 and 16 tokens for the three widths, so every capacity edge is reachable with short sequences. The small depth lets the bench place a high bound past the 32-bit capacity and probe the fault there. It can also write bytes and read them back as halves and words to confirm lane packing. Segments only a few tokens long let each stream run reach its end-of-segment fault within a handful of handshakes, including the same-cycle clear-versus-set case.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
    localparam logic [1:0] MD_RAND = 2'd0;
    localparam logic [1:0] MD_OUT  = 2'd1;
    localparam logic [1:0] MD_IN   = 2'd2;

    localparam logic [1:0] SZ_8  = 2'd0;
    localparam logic [1:0] SZ_16 = 2'd1;
    localparam logic [1:0] SZ_32 = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RAND = 3'd1,
        ST_SRC  = 3'd2,
        ST_SNK  = 3'd3,
        ST_END  = 3'd4
    } state_e;
endpackage

// File: rtl/ssm_lane_map.sv
module ssm_lane_map
    import ssm_pkg::*;
#(
    parameter int AW = 4,
    localparam int TA_W = AW + 2
) (
    input  logic [1:0]      size,
    input  logic [TA_W:0]   taddr,
    input  logic [31:0]     wtok,
    input  logic [31:0]     rword,
    output logic [AW-1:0]   widx,
    output logic [3:0]      ben,
    output logic [31:0]     wword,
    output logic [31:0]     rtok,
    output logic            fits
);
    logic [1:0]  lane;
    logic [31:0] shifted;

    always_comb begin
        unique case (size)
            SZ_8: begin
                widx  = taddr[AW+1:2];
                lane  = taddr[1:0];
                fits  = (taddr[TA_W] == 1'b0);
                ben   = 4'b0001 << lane;
                wword = {4{wtok[7:0]}};
            end
            SZ_16: begin
                widx  = taddr[AW:1];
                lane  = {taddr[0], 1'b0};
                fits  = (taddr[TA_W:TA_W-1] == 2'b00);
                ben   = 4'b0011 << lane;
                wword = {2{wtok[15:0]}};
            end
            default: begin
                widx  = taddr[AW-1:0];
                lane  = 2'b00;
                fits  = (taddr[TA_W:TA_W-2] == 3'b000);
                ben   = 4'b1111;
                wword = wtok;
            end
        endcase
        shifted = rword >> {lane, 3'b000};
        unique case (size)
            SZ_8:    rtok = {24'b0, shifted[7:0]};
            SZ_16:   rtok = {16'b0, shifted[15:0]};
            default: rtok = shifted;
        endcase
    end
endmodule

// File: rtl/ssm_store.sv
module ssm_store #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [3:0]    ben,
    input  logic [31:0]   wword,
    output logic [31:0]   rword
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (ben[b]) mem[widx][8*b +: 8] <= wword[8*b +: 8];
            end
        end
    end

    assign rword = mem[widx];
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int AW = 4,
    localparam int TA_W = AW + 2,
    localparam int PW = TA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic [1:0]      cfg_size,
    input  logic [TA_W-1:0] cfg_lo,
    input  logic [TA_W-1:0] cfg_hi,
    input  logic            cmd_go,
    input  logic            cmd_stop,
    input  logic            ra_en,
    input  logic            ra_we,
    input  logic [TA_W-1:0] ra_addr,
    input  logic            so_ready,
    input  logic            si_valid,
    input  logic            fault_clr,
    input  logic            fits,
    input  logic [31:0]     rtok,
    output logic [1:0]      size_q,
    output logic [PW-1:0]   acc_addr,
    output logic            rand_sel,
    output logic            mem_we,
    output logic            so_valid,
    output logic            si_ready,
    output logic            busy,
    output logic            fault,
    output logic [PW-1:0]   fault_addr,
    output logic [31:0]     ra_rdata,
    output logic            ra_rvalid
);
    state_e          state_q, state_d;
    logic [1:0]      mode_q;
    logic [TA_W-1:0] lo_q, hi_q;
    logic [PW-1:0]   ptr_q;
    logic            fault_q;
    logic [PW-1:0]   faddr_q;
    logic [31:0]     rdata_q;
    logic            rvalid_q;

    logic seg_ok, fault_hit, cfg_ok, go_ok, step;

    // Output / datapath decode
    always_comb begin
        rand_sel  = (state_q == ST_RAND);
        acc_addr  = rand_sel ? {1'b0, ra_addr} : ptr_q;
        seg_ok    = (acc_addr >= {1'b0, lo_q}) && (acc_addr <= {1'b0, hi_q}) && fits;
        so_valid  = (state_q == ST_SRC) && seg_ok;
        si_ready  = (state_q == ST_SNK) && seg_ok;
        mem_we    = ((state_q == ST_SNK) && si_valid && seg_ok) ||
                    (rand_sel && ra_en && ra_we && seg_ok);
        fault_hit = (((state_q == ST_SRC) || (state_q == ST_SNK)) && !seg_ok) ||
                    (rand_sel && ra_en && !seg_ok);
        cfg_ok    = (state_q == ST_IDLE) && cfg_we &&
                    (cfg_mode != 2'd3) && (cfg_size != 2'd3);
        go_ok     = (state_q == ST_IDLE) && cmd_go;
        step      = (so_valid && so_ready) || (si_valid && si_ready);
        busy      = (state_q != ST_IDLE);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_go) begin
                unique case (mode_q)
                    MD_RAND: state_d = ST_RAND;
                    MD_OUT:  state_d = ST_SRC;
                    default: state_d = ST_SNK;
                endcase
            end
            ST_RAND: if (cmd_stop) state_d = ST_IDLE;
            ST_SRC, ST_SNK: begin
                if (cmd_stop)     state_d = ST_IDLE;
                else if (!seg_ok) state_d = ST_END;
            end
            ST_END:  if (cmd_stop) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Configuration, pointer, fault and read-data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MD_RAND;
            size_q   <= SZ_32;
            lo_q     <= '0;
            hi_q     <= '0;
            ptr_q    <= '0;
            fault_q  <= 1'b0;
            faddr_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (cfg_ok) begin
                mode_q <= cfg_mode;
                size_q <= cfg_size;
                lo_q   <= cfg_lo;
                hi_q   <= cfg_hi;
                ptr_q  <= {1'b0, cfg_lo};
            end else if (go_ok) begin
                ptr_q  <= {1'b0, lo_q};
            end else if (step) begin
                ptr_q  <= ptr_q + 1'b1;
            end
            if (fault_hit) begin
                fault_q <= 1'b1;
                if (!fault_q || fault_clr) faddr_q <= acc_addr;
            end else if (fault_clr) begin
                fault_q <= 1'b0;
            end
            rvalid_q <= rand_sel && ra_en && !ra_we && seg_ok;
            if (rand_sel && ra_en && !ra_we && seg_ok) rdata_q <= rtok;
        end
    end

    assign fault      = fault_q;
    assign fault_addr = faddr_q;
    assign ra_rdata   = rdata_q;
    assign ra_rvalid  = rvalid_q;

    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SRC && so_valid && so_ready) |=> (ptr_q == $past(ptr_q) + 1'b1))
        else $error("stream pointer did not advance by one");

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(lo_q) && $stable(hi_q) && $stable(mode_q) && $stable(size_q)))
        else $error("configuration changed while busy");

    assert_end_faulted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_END) |-> fault_q)
        else $error("halt without fault");

    assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !fault_clr) |=> fault_q)
        else $error("fault dropped without clear");

    assert_fault_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !fault_clr) |=> $stable(faddr_q))
        else $error("fault address overwritten");

    assert_one_stream_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(so_valid && si_ready))
        else $error("both stream ports live");

    assert_no_fault_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !fault_hit)
        else $error("write on faulting access");
endmodule

// File: rtl/seg_stream_mem.sv
module seg_stream_mem
    import ssm_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int TA_W = AW + 2,
    localparam int PW = TA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_mode,
    input  logic [1:0]      cfg_size,
    input  logic [TA_W-1:0] cfg_lo,
    input  logic [TA_W-1:0] cfg_hi,
    input  logic            cmd_go,
    input  logic            cmd_stop,
    output logic            busy,
    input  logic            ra_en,
    input  logic            ra_we,
    input  logic [TA_W-1:0] ra_addr,
    input  logic [31:0]     ra_wdata,
    output logic [31:0]     ra_rdata,
    output logic            ra_rvalid,
    output logic            so_valid,
    input  logic            so_ready,
    output logic [31:0]     so_data,
    input  logic            si_valid,
    output logic            si_ready,
    input  logic [31:0]     si_data,
    output logic            fault,
    output logic [PW-1:0]   fault_addr,
    input  logic            fault_clr
);
    logic [1:0]    size_q;
    logic [PW-1:0] acc_addr;
    logic          rand_sel, mem_we, fits;
    logic [AW-1:0] widx;
    logic [3:0]    ben;
    logic [31:0]   wtok, wword, rword, rtok;

    assign wtok    = rand_sel ? ra_wdata : si_data;
    assign so_data = rtok;

    ssm_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_size(cfg_size),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cmd_go(cmd_go), .cmd_stop(cmd_stop),
        .ra_en(ra_en), .ra_we(ra_we), .ra_addr(ra_addr),
        .so_ready(so_ready), .si_valid(si_valid), .fault_clr(fault_clr),
        .fits(fits), .rtok(rtok),
        .size_q(size_q), .acc_addr(acc_addr), .rand_sel(rand_sel),
        .mem_we(mem_we), .so_valid(so_valid), .si_ready(si_ready),
        .busy(busy), .fault(fault), .fault_addr(fault_addr),
        .ra_rdata(ra_rdata), .ra_rvalid(ra_rvalid)
    );

    ssm_lane_map #(.AW(AW)) u_lane (
        .size(size_q), .taddr(acc_addr), .wtok(wtok), .rword(rword),
        .widx(widx), .ben(ben), .wword(wword), .rtok(rtok), .fits(fits)
    );

    ssm_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(mem_we), .widx(widx), .ben(ben),
        .wword(wword), .rword(rword)
    );
endmodule

// File: tb/tb_seg_stream_mem.sv
module tb_seg_stream_mem;
    localparam int CLK_PERIOD = 10;
    localparam int TA_W = 6;
    localparam int PW = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 0, cmd_go = 0, cmd_stop = 0;
    logic [1:0]      cfg_mode = 0, cfg_size = 0;
    logic [TA_W-1:0] cfg_lo = 0, cfg_hi = 0, ra_addr = 0;
    logic            ra_en = 0, ra_we = 0, so_ready = 0, si_valid = 0, fault_clr = 0;
    logic [31:0]     ra_wdata = 0, si_data = 0;
    logic            busy, ra_rvalid, so_valid, si_ready, fault;
    logic [31:0]     ra_rdata, so_data;
    logic [PW-1:0]   fault_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_stream_mem dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_size(cfg_size), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cmd_go(cmd_go), .cmd_stop(cmd_stop), .busy(busy),
        .ra_en(ra_en), .ra_we(ra_we), .ra_addr(ra_addr), .ra_wdata(ra_wdata),
        .ra_rdata(ra_rdata), .ra_rvalid(ra_rvalid),
        .so_valid(so_valid), .so_ready(so_ready), .so_data(so_data),
        .si_valid(si_valid), .si_ready(si_ready), .si_data(si_data),
        .fault(fault), .fault_addr(fault_addr), .fault_clr(fault_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] m, input logic [1:0] s,
                       input logic [TA_W-1:0] lo, input logic [TA_W-1:0] hi);
        @(negedge clk);
        cfg_we = 1; cfg_mode = m; cfg_size = s; cfg_lo = lo; cfg_hi = hi;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic go();
        @(negedge clk); cmd_go = 1;
        @(negedge clk); cmd_go = 0;
    endtask

    task automatic stop();
        @(negedge clk); cmd_stop = 1;
        @(negedge clk); cmd_stop = 0;
    endtask

    task automatic clear_fault();
        @(negedge clk); fault_clr = 1;
        @(negedge clk); fault_clr = 0;
    endtask

    task automatic ra_wr(input logic [TA_W-1:0] a, input logic [31:0] d);
        @(negedge clk); ra_en = 1; ra_we = 1; ra_addr = a; ra_wdata = d;
        @(negedge clk); ra_en = 0; ra_we = 0;
    endtask

    task automatic ra_rd(input logic [TA_W-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk); ra_en = 1; ra_we = 0; ra_addr = a;
        @(negedge clk); d = ra_rdata; v = ra_rvalid; ra_en = 0;
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 fault", {31'b0, fault}, 0);
        chk("R1 so_valid", {31'b0, so_valid}, 0);
        chk("R1 si_ready", {31'b0, si_ready}, 0);
    endtask

    task automatic t_pack();
        logic [31:0] d; logic v;
        cfg(2'd0, 2'd0, 6'd0, 6'd63);
        go();
        chk("R3 busy after go", {31'b0, busy}, 1);
        ra_wr(6'd0, 32'h11); ra_wr(6'd1, 32'h22);
        ra_wr(6'd2, 32'h33); ra_wr(6'd3, 32'h44);
        ra_rd(6'd2, d, v);
        chk("R4 byte read data", d, 32'h33);
        chk("R4 read valid", {31'b0, v}, 1);
        stop();
        chk("R3 idle after stop", {31'b0, busy}, 0);
        cfg(2'd0, 2'd2, 6'd0, 6'd15); go();
        ra_rd(6'd0, d, v);
        chk("R5 word of four bytes", d, 32'h44332211);
        stop();
        cfg(2'd0, 2'd1, 6'd0, 6'd31); go();
        ra_rd(6'd1, d, v);
        chk("R5 upper half", d, 32'h4433);
        stop();
    endtask

    task automatic t_stream_out();
        logic [31:0] exp_tok [3];
        exp_tok[0] = 32'h22; exp_tok[1] = 32'h33; exp_tok[2] = 32'h44;
        cfg(2'd1, 2'd0, 6'd1, 6'd3); go();
        chk("R6 first valid", {31'b0, so_valid}, 1);
        chk("R6 first token at low bound", so_data, 32'h22);
        chk("R11 no sink ready in stream-out", {31'b0, si_ready}, 0);
        ra_wr(6'd1, 32'h5A);
        chk("R11 random write ignored", so_data, 32'h22);
        chk("R6 hold under back-pressure", {31'b0, so_valid}, 1);
        so_ready = 1;
        for (int i = 0; i < 3; i++) begin
            chk("R6 stream valid", {31'b0, so_valid}, 1);
            chk("R6 stream token order", so_data, exp_tok[i]);
            @(negedge clk);
        end
        so_ready = 0;
        chk("R7 valid drops past high bound", {31'b0, so_valid}, 0);
        @(negedge clk);
        chk("R7 fault set", {31'b0, fault}, 1);
        chk("R7 fault address high+1", {25'b0, fault_addr}, 32'd4);
        chk("R7 halted busy", {31'b0, busy}, 1);
        @(negedge clk);
        chk("R7 no wrap", {31'b0, so_valid}, 0);
        stop();
        chk("R10 fault sticky across stop", {31'b0, fault}, 1);
    endtask

    task automatic t_oob_random();
        logic [31:0] d; logic v;
        clear_fault();
        chk("R10 clear", {31'b0, fault}, 0);
        cfg(2'd0, 2'd0, 6'd8, 6'd15); go();
        ra_wr(6'd2, 32'h99);
        chk("R9 fault on oob write", {31'b0, fault}, 1);
        chk("R9 fault address", {25'b0, fault_addr}, 32'd2);
        ra_rd(6'd3, d, v);
        chk("R9 no rvalid on oob read", {31'b0, v}, 0);
        chk("R10 first address kept", {25'b0, fault_addr}, 32'd2);
        stop();
        cfg(2'd0, 2'd0, 6'd0, 6'd63); go();
        ra_rd(6'd2, d, v);
        chk("R9 oob write did not store", d, 32'h33);
        stop();
        cfg(2'd0, 2'd2, 6'd0, 6'd3); go();
        @(negedge clk); fault_clr = 1; ra_en = 1; ra_we = 0; ra_addr = 6'd9;
        @(negedge clk); fault_clr = 0; ra_en = 0;
        chk("R10 set wins over clear", {31'b0, fault}, 1);
        chk("R10 new address on set-with-clear", {25'b0, fault_addr}, 32'd9);
        clear_fault();
        stop();
    endtask

    task automatic t_stream_in();
        logic [31:0] d; logic v;
        cfg(2'd2, 2'd1, 6'd4, 6'd5); go();
        chk("R8 ready in segment", {31'b0, si_ready}, 1);
        chk("R11 no source valid in stream-in", {31'b0, so_valid}, 0);
        si_valid = 1; si_data = 32'h0000AAAA;
        @(negedge clk);
        si_data = 32'h0000BBBB;
        chk("R8 ready second token", {31'b0, si_ready}, 1);
        @(negedge clk);
        si_valid = 0;
        chk("R8 ready drops past high", {31'b0, si_ready}, 0);
        @(negedge clk);
        chk("R8 fault address high+1", {25'b0, fault_addr}, 32'd6);
        stop(); clear_fault();
        cfg(2'd0, 2'd2, 6'd0, 6'd15); go();
        ra_rd(6'd2, d, v);
        chk("R8 captured halves", d, 32'hBBBBAAAA);
    endtask

    task automatic t_cfg_rules();
        logic [31:0] d; logic v;
        cfg(2'd1, 2'd0, 6'd3, 6'd3);
        ra_rd(6'd10, d, v);
        chk("R2 busy config ignored, bounds kept", {31'b0, v}, 1);
        chk("R2 no fault", {31'b0, fault}, 0);
        chk("R2 mode kept", {31'b0, so_valid}, 0);
        stop();
        cfg(2'd3, 2'd0, 6'd0, 6'd0);
        go();
        chk("R2 reserved mode rejected, no stream", {31'b0, so_valid | si_ready}, 0);
        ra_rd(6'd2, d, v);
        chk("R2 previous config still active", d, 32'hBBBBAAAA);
        stop();
    endtask

    task automatic t_bounds();
        logic [31:0] d; logic v;
        cfg(2'd0, 2'd2, 6'd0, 6'd20); go();
        ra_rd(6'd16, d, v);
        chk("R12 beyond capacity no rvalid", {31'b0, v}, 0);
        chk("R12 beyond capacity fault address", {25'b0, fault_addr}, 32'd16);
        stop(); clear_fault();
        cfg(2'd1, 2'd0, 6'd5, 6'd2); go();
        chk("R12 inverted segment no valid", {31'b0, so_valid}, 0);
        @(negedge clk);
        chk("R12 inverted segment fault", {31'b0, fault}, 1);
        chk("R12 inverted segment fault address", {25'b0, fault_addr}, 32'd5);
        stop(); clear_fault();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pack();
        t_stream_out();
        t_oob_random();
        t_stream_in();
        t_cfg_rules();
        t_bounds();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule